// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block is the host side of a six-channel simultaneous-sampling converter that talks over a three-wire serial link: a convert strobe, a serial clock, and one serial data line back from the converter. On a frame request the controller raises the convert strobe, which samples every enabled input at the same instant. Half a serial clock period later it starts the serial clock. It then runs one 16-clock slot per enabled channel, captures the 12 result bits of each slot, and hands every result, tagged with its channel index, to a valid/ready output.

A 3-bit select input sets how many channels take part in a frame, and so how long the frame is. A polarity input chooses how results are reported: straight binary for the unipolar range, or two's complement for the bipolar range. Frames run one per request, or back to back while the free-run input is high. The next convert strobe never rises before the last rising serial clock of the frame in progress. Results are held in a small buffer. A new frame starts only once every result of the previous frame has been taken, so no result is ever lost or overwritten.

The serial clock is the system clock divided by a parameter. It is low while the controller is idle.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `adc_conv_o` and `adc_sclk_o` are low and `res_valid_o` is low.
- R2: Each frame raises `adc_conv_o` while `adc_sclk_o` is low. The first rising serial clock follows exactly `SCLK_HALF` system clocks later, and the strobe falls at that same edge.
- R3: A frame has 16 rising serial clocks per enabled channel. A select value k from 0 to 5 enables channels 0 through k. Values 6 and 7 enable all six channels.
- R4: Serial data is sampled at each rising serial clock. In each 16-clock slot, positions 0 to 11 carry the result MSB first, and the data at positions 12 to 15 has no effect on any result.
- R5: Results leave in ascending channel order, each carrying its channel index. While `res_valid_o` is high and `res_ready_i` is low, the output word and the index stay unchanged.
- R6: With polarity low, the 12 received bits are reported unchanged as straight binary. With polarity high, the converter sends offset binary (midscale 0x800), and the result is reported as two's complement, i.e. with the MSB inverted (0x800 becomes 0x000, 0xFFF becomes 0x7FF, 0x000 becomes 0x800).
- R7: Select and polarity are captured when a frame starts. Changing them during a frame does not alter that frame's length or its results.
- R8: A convert strobe never rises before the final rising serial clock of the previous frame. When a frame follows directly, the strobe rises `SCLK_HALF` system clocks after that final rising edge.
- R9: A request made while a frame is running is held and served right after that frame. While `free_run_i` is high, frames repeat without requests.
- R10: A new frame starts only when no result of the previous frame is still waiting in the buffer or on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req_i | input | 1 | One-cycle request for a single frame |
| free_run_i | input | 1 | High: run frames back to back |
| chan_sel_i | input | 3 | Channel count select (k enables channels 0..k) |
| bipolar_i | input | 1 | High: bipolar range, two's complement results |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_conv_o | output | 1 | Convert strobe; rising edge samples all inputs |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Downstream accepts the result |
| res_data_o | output | 12 | Result word |
| res_chan_o | output | 3 | Channel index of the result |

## Verification
The bench builds the block with its defaults: `SCLK_HALF` = 2, six channels, 12-bit results and 16-clock slots. The serial clock period is then 40 ns, so the half-period lead and the back-to-back gap can be checked as exact 20 ns intervals. A full frame ends within about 400 system clocks, which leaves room to run single-channel, partial and full frames, held requests, free-running sequences and long backpressure stalls in one run. The converter model drives the four ignored slot positions high, so any leak of those bits into a result would show up as a wrong data word.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_RUN  = 2'd2
  } rd_state_t;

  // Select value k enables channels 0..k, clamped to the channel count.
  function automatic int unsigned chans_enabled(input int unsigned sel,
                                                input int unsigned nch);
    return (sel + 1 >= nch) ? nch : sel + 1;
  endfunction

endpackage

// File: rtl/adcrd_tick.sv
`timescale 1ns/1ps
module adcrd_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adcrd_shift.sv
`timescale 1ns/1ps
module adcrd_shift #(
  parameter int RES_W     = 12,
  parameter int SLOT_CLKS = 16,
  parameter int CH_W      = 3,
  parameter int POS_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rise,
  input  logic             sdo,
  input  logic             bipolar,
  output logic             push,
  output logic [RES_W-1:0] push_word,
  output logic [CH_W-1:0]  push_chan,
  output logic [CH_W-1:0]  slot_o
);
  logic [POS_W-1:0] pos;
  logic [CH_W-1:0]  slot;
  logic [RES_W-2:0] sh;

  assign push      = rise && (pos == POS_W'(RES_W - 1));
  assign push_word = {sh, sdo} ^ {bipolar, {(RES_W-1){1'b0}}};
  assign push_chan = slot;
  assign slot_o    = slot;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos  <= '0;
      slot <= '0;
      sh   <= '0;
    end else if (rise) begin
      if (pos < POS_W'(RES_W - 1)) sh <= {sh[RES_W-3:0], sdo};
      if (pos == POS_W'(SLOT_CLKS - 1)) begin
        pos  <= '0;
        slot <= slot + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcrd_fifo.sv
`timescale 1ns/1ps
module adcrd_fifo #(
  parameter int W         = 15,
  parameter int DEPTH_MIN = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         idle
);
  localparam int AW    = (DEPTH_MIN > 1) ? $clog2(DEPTH_MIN) : 1;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          rd;

  assign rd   = (cnt != '0) && (!out_valid || out_ready);
  assign idle = (cnt == '0) && !out_valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd) out_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd)    rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd);
      if (rd)             out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
`timescale 1ns/1ps
module adc_frame_reader #(
  parameter  int SCLK_HALF = 2,
  parameter  int NCH       = 6,
  parameter  int RES_W     = 12,
  parameter  int SLOT_CLKS = 16,
  parameter  int SEL_W     = 3,
  localparam int CH_W      = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_req_i,
  input  logic             free_run_i,
  input  logic [SEL_W-1:0] chan_sel_i,
  input  logic             bipolar_i,
  input  logic             adc_sdo_i,
  output logic             adc_conv_o,
  output logic             adc_sclk_o,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [RES_W-1:0] res_data_o,
  output logic [CH_W-1:0]  res_chan_o
);
  import adcrd_pkg::*;

  localparam int POS_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int FW    = CH_W + RES_W;

  rd_state_t         state;
  logic              sclk_q, conv_q, pend_q, bip_q;
  logic [CH_W-1:0]   nch_q;
  logic              tick, rise, fall_tick, frame_done, launch, buf_idle;
  logic              push;
  logic [RES_W-1:0]  push_word;
  logic [CH_W-1:0]   push_chan, slot;
  logic [FW-1:0]     out_word;

  assign rise       = tick && ((state == ST_CONV) || (state == ST_RUN && !sclk_q));
  assign fall_tick  = tick && (state == ST_RUN) && sclk_q;
  assign frame_done = fall_tick && (slot == nch_q);
  assign launch     = ((state == ST_IDLE) || frame_done) && (pend_q || free_run_i) && buf_idle;

  adcrd_tick #(.HALF(SCLK_HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (state != ST_IDLE),
    .tick(tick)
  );

  adcrd_shift #(
    .RES_W(RES_W), .SLOT_CLKS(SLOT_CLKS), .CH_W(CH_W), .POS_W(POS_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (launch),
    .rise     (rise),
    .sdo      (adc_sdo_i),
    .bipolar  (bip_q),
    .push     (push),
    .push_word(push_word),
    .push_chan(push_chan),
    .slot_o   (slot)
  );

  adcrd_fifo #(.W(FW), .DEPTH_MIN(NCH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push),
    .wr_data  ({push_chan, push_word}),
    .out_valid(res_valid_o),
    .out_ready(res_ready_i),
    .out_data (out_word),
    .idle     (buf_idle)
  );

  assign res_chan_o = out_word[FW-1:RES_W];
  assign res_data_o = out_word[RES_W-1:0];
  assign adc_conv_o = conv_q;
  assign adc_sclk_o = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sclk_q <= 1'b0;
      conv_q <= 1'b0;
      pend_q <= 1'b0;
      bip_q  <= 1'b0;
      nch_q  <= '0;
    end else begin
      if (launch)           pend_q <= frame_req_i;
      else if (frame_req_i) pend_q <= 1'b1;

      if (launch) begin
        state  <= ST_CONV;
        conv_q <= 1'b1;
        sclk_q <= 1'b0;
        nch_q  <= CH_W'(chans_enabled(32'(chan_sel_i), NCH));
        bip_q  <= bipolar_i;
      end else begin
        case (state)
          ST_CONV: if (tick) begin
            sclk_q <= 1'b1;
            conv_q <= 1'b0;
            state  <= ST_RUN;
          end
          ST_RUN: if (tick) begin
            sclk_q <= !sclk_q;
            if (frame_done) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adcrd_checker.sv
`timescale 1ns/1ps
module adcrd_checker #(
  parameter int NCH       = 6,
  parameter int RES_W     = 12,
  parameter int SLOT_CLKS = 16,
  parameter int CH_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_conv_o,
  input logic             adc_sclk_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [RES_W-1:0] res_data_o,
  input logic [CH_W-1:0]  res_chan_o
);
  localparam int MAXR = NCH * SLOT_CLKS;
  localparam int RW   = $clog2(MAXR + 1) + 1;

  logic [RW-1:0] rises;
  logic          sclk_d, conv_d, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rises  <= '0;
      sclk_d <= 1'b0;
      conv_d <= 1'b0;
      seen   <= 1'b0;
    end else begin
      sclk_d <= adc_sclk_o;
      conv_d <= adc_conv_o;
      if (adc_conv_o && !conv_d) begin
        rises <= '0;
        seen  <= 1'b1;
      end else if (adc_sclk_o && !sclk_d) begin
        rises <= rises + 1'b1;
      end
    end
  end

  // R2: strobe high only while the serial clock is low
  p_conv_sclk_low_r2: assert property (@(posedge clk) disable iff (rst)
    adc_conv_o |-> !adc_sclk_o);

  // R8: a strobe only after a whole number of slots
  p_conv_after_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (adc_conv_o && !conv_d && seen) |-> ((rises % SLOT_CLKS) == 0 && rises != 0));

  // R3: a frame never exceeds the full channel count
  p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
    rises <= RW'(MAXR));

  // R5: output held under backpressure
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_chan_o)));

  // R5: channel index in range
  p_chan_range_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (res_chan_o < CH_W'(NCH)));

  // R10: no frame starts while a result is still offered
  p_start_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (adc_conv_o && !conv_d) |-> !res_valid_o);
endmodule

bind adc_frame_reader adcrd_checker #(
  .NCH(NCH), .RES_W(RES_W), .SLOT_CLKS(SLOT_CLKS), .CH_W(CH_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adc_conv_o (adc_conv_o),
  .adc_sclk_o (adc_sclk_o),
  .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i),
  .res_data_o (res_data_o),
  .res_chan_o (res_chan_o)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
  localparam int HALF = 2;

  logic        clk = 1'b0, rst = 1'b1;
  logic        frame_req_i = 1'b0, free_run_i = 1'b0, bipolar_i = 1'b0;
  logic [2:0]  chan_sel_i = 3'd0;
  logic        adc_sdo_i = 1'b0;
  logic        adc_conv_o, adc_sclk_o, res_valid_o;
  logic        res_ready_i = 1'b1;
  logic [11:0] res_data_o;
  logic [2:0]  res_chan_o;

  int n_checks = 0, n_err = 0;
  bit done = 0;

  adc_frame_reader #(.SCLK_HALF(HALF)) uut (.*);

  always #5 clk = ~clk;

  // converter model
  logic [11:0] words [6];
  int  bit_idx = 0, rises = 0, frames = 0;
  realtime conv_t = 0, last_rise_t = 0;
  int  lead_ns = -1, gap_ns = -1;
  bit  first_pend = 0;

  function automatic logic model_bit(input int i);
    int s, p;
    s = i / 16; p = i % 16;
    if (s > 5) return 1'b0;
    if (p < 12) return words[s][11-p];
    return 1'b1;
  endfunction

  always @(posedge adc_conv_o) begin
    conv_t = $realtime;
    if (frames > 0) gap_ns = int'(conv_t - last_rise_t);
    frames++;
    bit_idx = 0;
    adc_sdo_i = model_bit(0);
    first_pend = 1;
  end

  always @(negedge adc_sclk_o) begin
    bit_idx++;
    adc_sdo_i = model_bit(bit_idx);
  end

  always @(posedge adc_sclk_o) begin
    rises++;
    last_rise_t = $realtime;
    if (first_pend) begin
      lead_ns = int'($realtime - conv_t);
      first_pend = 0;
    end
  end

  // result collector
  logic [11:0] got_data [64];
  logic [2:0]  got_chan [64];
  int n_got = 0;
  always @(negedge clk) begin
    if (res_valid_o && res_ready_i && n_got < 64) begin
      got_data[n_got] = res_data_o;
      got_chan[n_got] = res_chan_o;
      n_got++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_req();
    frame_req_i = 1'b1;
    drive_wait(1);
    frame_req_i = 1'b0;
  endtask

  task automatic wait_results(input int n);
    for (int i = 0; i < 4000 && n_got < n; i++) drive_wait(1);
  endtask

  task automatic clear_stats();
    n_got = 0; rises = 0; frames = 0; gap_ns = -1; lead_ns = -1;
  endtask

  task automatic t_reset();
    chk("R1 conv after reset", int'(adc_conv_o), 0);
    chk("R1 sclk after reset", int'(adc_sclk_o), 0);
    chk("R1 valid after reset", int'(res_valid_o), 0);
  endtask

  task automatic t_frame(input int sel, input bit bip, input int nexp);
    clear_stats();
    chan_sel_i = 3'(sel); bipolar_i = bip;
    pulse_req();
    wait_results(nexp);
    drive_wait(40);
    chk("R3 result count", n_got, nexp);
    chk("R3 rises per frame", rises, 16 * nexp);
    chk("R2 conv lead ns", lead_ns, HALF * 10);
    for (int i = 0; i < nexp; i++) begin
      chk("R5 channel order", int'(got_chan[i]), i);
      if (bip) chk("R6 bipolar two's complement", int'(got_data[i]), int'(words[i] ^ 12'h800));
      else     chk("R4 R6 straight binary data", int'(got_data[i]), int'(words[i]));
    end
  endtask

  task automatic t_midframe_change();
    clear_stats();
    chan_sel_i = 3'd1; bipolar_i = 1'b0;
    pulse_req();
    drive_wait(10);
    chan_sel_i = 3'd5; bipolar_i = 1'b1;
    wait_results(2);
    drive_wait(60);
    chk("R7 length kept", rises, 32);
    chk("R7 count kept", n_got, 2);
    chk("R7 polarity kept ch0", int'(got_data[0]), int'(words[0]));
    chk("R7 polarity kept ch1", int'(got_data[1]), int'(words[1]));
  endtask

  task automatic t_held_request();
    clear_stats();
    chan_sel_i = 3'd0; bipolar_i = 1'b0;
    pulse_req();
    drive_wait(20);
    pulse_req();
    wait_results(2);
    drive_wait(40);
    chk("R9 held request served", frames, 2);
    chk("R8 back-to-back gap ns", gap_ns, HALF * 10);
    chk("R9 results", n_got, 2);
  endtask

  task automatic t_free_run();
    clear_stats();
    chan_sel_i = 3'd1; bipolar_i = 1'b0;
    free_run_i = 1'b1;
    for (int i = 0; i < 4000 && frames < 3; i++) drive_wait(1);
    free_run_i = 1'b0;
    drive_wait(400);
    chk("R9 free run repeats", int'(frames >= 3), 1);
    chk("R9 all frames delivered", n_got, 2 * frames);
    chk("R8 free-run gap ns", gap_ns, HALF * 10);
  endtask

  task automatic t_backpressure();
    clear_stats();
    chan_sel_i = 3'd2; bipolar_i = 1'b0;
    res_ready_i = 1'b0;
    free_run_i = 1'b1;
    drive_wait(1200);
    chk("R10 no frame while buffered", frames, 1);
    chk("R5 held valid", int'(res_valid_o), 1);
    chk("R5 held channel", int'(res_chan_o), 0);
    chk("R5 held data", int'(res_data_o), int'(words[0]));
    res_ready_i = 1'b1;
    wait_results(3);
    drive_wait(2);
    for (int i = 0; i < 3; i++) chk("R5 order after stall", int'(got_chan[i]), i);
    for (int i = 0; i < 4000 && frames < 2; i++) drive_wait(1);
    free_run_i = 1'b0;
    drive_wait(400);
    chk("R10 restart after drain", int'(frames >= 2), 1);
    chk("R10 nothing lost", n_got, 3 * frames);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    words[0] = 12'hABC; words[1] = 12'h001; words[2] = 12'hFFF;
    words[3] = 12'h000; words[4] = 12'h555; words[5] = 12'h8F0;
    drive_wait(4);
    rst = 1'b0;
    drive_wait(2);
    t_reset();
    t_frame(5, 1'b0, 6);
    t_frame(0, 1'b0, 1);
    t_frame(7, 1'b0, 6);
    t_frame(6, 1'b0, 6);
    words[0] = 12'h800; words[1] = 12'hFFF; words[2] = 12'h000;
    t_frame(2, 1'b1, 3);
    words[0] = 12'h3C5; words[1] = 12'hC3A;
    t_midframe_change();
    t_held_request();
    t_free_run();
    t_backpressure();
    finish_run();
  end
endmodule